// File: doc/BRIEF.md
# I2C SCL Divisor Setting Calculator

This block turns two frequencies into the pair of divisor codes that an I2C clock generator needs. It takes the module clock rate and the requested SCL rate, both 32-bit unsigned values in Hz. The generator makes each SCL half-period last eight module clocks per code step plus one. The block sets the high and low codes separately so that the LOW phase meets the bus minimum for each speed class.

A start pulse latches the two rates. The block chooses a high:low weighting from the speed class of the request and runs two round-up divisions in turn on one shared restoring divider. The first division gives the LOW share of the period. The second gives the total period in eight-clock units. The HIGH share is the total minus the LOW share, so rounding in the LOW share does not change the overall SCL rate. When both codes are registered, `ready` pulses for one cycle. A zero SCL request raises an error flag instead.

Top module: `scl_div_calc`

## Requirements
- R1: A request of at most 100000 Hz (100000 itself included) uses the weighting high 40 : low 47.
- R2: A request above 100000 Hz and at most 400000 Hz uses high 6 : low 13.
- R3: A request above 400000 Hz and at most 1000000 Hz uses high 26 : low 50.
- R4: A request above 1000000 Hz uses high 6 : low 16.
- R5: With weights h:l, the LOW total is LT = ceil(fclk·l / (fscl·8·(h+l))). `lo_code` is LT−1, or 0 when LT is 0.
- R6: The whole total is T = ceil(fclk / (fscl·8)). `hi_code` is (T−LT)−1, and it stays 0 when T−LT is 0. For example, fclk 12.8 MHz with fscl 400 kHz gives lo_code 2 and hi_code 0.
- R7: A code whose value would exceed 0xFFFF is delivered as 0xFFFF.
- R8: A start with fscl equal to 0 sets `fault`, drives both codes to 0 and still pulses `ready`. The next start with a nonzero fscl clears `fault`.
- R9: A start pulse that arrives while `busy` is high has no effect. No extra `ready` pulse follows, and the codes reflect only the first request.
- R10: `ready` is high for exactly one cycle per accepted request. The codes and `fault` change only in the cycle where `ready` is high.
- R11: After reset, `busy`, `ready` and `fault` are 0 and both codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe, honoured only when idle |
| fclk_hz | input | 32 | Module clock rate in Hz |
| fscl_hz | input | 32 | Requested SCL rate in Hz |
| busy | output | 1 | High while a request is being computed |
| ready | output | 1 | One-cycle pulse when the codes are updated |
| fault | output | 1 | Last request had a zero SCL rate |
| hi_code | output | 16 | HIGH-phase divisor code |
| lo_code | output | 16 | LOW-phase divisor code |

## Verification
The bench builds the block with its default parameters: a 64-bit divider, 32-bit rate inputs, 16-bit codes and the class limits of 100 kHz, 400 kHz and 1 MHz. These defaults let the bench drive rates right at and one Hz above each class limit, so every weighting is selected. The full 32-bit clock range also reaches the saturation path, including a case where only one of the two codes saturates. Tiny clock values reach the corner where the HIGH total is zero and the corner where the LOW total is zero.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_TOT  = 2'd2
  } calc_state_t;

  localparam int WEIGHT_W = 7;
endpackage

// File: rtl/scl_div_weights.sv
module scl_div_weights #(
  parameter int IN_W      = 32,
  parameter int W_W       = 7,
  parameter int LIM_STD   = 100000,
  parameter int LIM_FAST  = 400000,
  parameter int LIM_PLUS  = 1000000
) (
  input  logic [IN_W-1:0] fscl,
  output logic [W_W-1:0]  w_hi,
  output logic [W_W-1:0]  w_lo
);
  localparam logic [IN_W-1:0] L0 = IN_W'(LIM_STD);
  localparam logic [IN_W-1:0] L1 = IN_W'(LIM_FAST);
  localparam logic [IN_W-1:0] L2 = IN_W'(LIM_PLUS);

  always_comb begin
    if (fscl <= L0) begin
      w_hi = W_W'(40);
      w_lo = W_W'(47);
    end else if (fscl <= L1) begin
      w_hi = W_W'(6);
      w_lo = W_W'(13);
    end else if (fscl <= L2) begin
      w_hi = W_W'(26);
      w_lo = W_W'(50);
    end else begin
      w_hi = W_W'(6);
      w_lo = W_W'(16);
    end
  end
endmodule

// File: rtl/scl_div_divider.sv
module scl_div_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         vld,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          vld_q;
  logic [W:0]    rem_sh;
  logic          take;

  always_comb begin
    rem_sh = {rem_q[W-1:0], quo_q[W-1]};
    take   = rem_sh >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (!run_q) begin
        if (go) begin
          rem_q <= '0;
          quo_q <= num;
          den_q <= den;
          cnt_q <= CW'(W);
          run_q <= 1'b1;
        end
      end else begin
        rem_q <= take ? (rem_sh - {1'b0, den_q}) : rem_sh;
        quo_q <= {quo_q[W-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          vld_q <= 1'b1;
        end
      end
    end
  end

  assign busy = run_q;
  assign vld  = vld_q;
  assign quo  = quo_q;

  // R5: a finished division leaves a remainder below the divisor
  p_rem_lt_den_r5: assert property (@(posedge clk) disable iff (rst)
    vld |-> (rem_q < {1'b0, den_q}));
  // R10: the result pulse never lasts two cycles
  p_vld_single_r10: assert property (@(posedge clk) disable iff (rst)
    vld |=> !vld);
endmodule

// File: rtl/scl_div_calc.sv
module scl_div_calc #(
  parameter int IN_W     = 32,
  parameter int CODE_W   = 16,
  parameter int DW       = 64,
  parameter int LIM_STD  = 100000,
  parameter int LIM_FAST = 400000,
  parameter int LIM_PLUS = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IN_W-1:0]   fclk_hz,
  input  logic [IN_W-1:0]   fscl_hz,
  output logic              busy,
  output logic              ready,
  output logic              fault,
  output logic [CODE_W-1:0] hi_code,
  output logic [CODE_W-1:0] lo_code
);
  import scl_div_pkg::*;

  localparam int WW = WEIGHT_W;
  localparam logic [DW-1:0] CODE_MAX = DW'({CODE_W{1'b1}});

  function automatic logic [CODE_W-1:0] to_code(input logic [DW-1:0] t);
    if (t == '0)
      return '0;
    else if ((t - 1'b1) > CODE_MAX)
      return {CODE_W{1'b1}};
    else
      return CODE_W'(t - 1'b1);
  endfunction

  calc_state_t       st_q;
  logic [IN_W-1:0]   fclk_q, fscl_q;
  logic [DW-1:0]     num_q, den_q, lt_q;
  logic              go_q;
  logic              ready_q, fault_q;
  logic [CODE_W-1:0] hi_q, lo_q;
  logic [WW-1:0]     w_hi, w_lo;
  logic [DW-1:0]     den_low, num_low, unit_q;
  logic              dv_busy, dv_vld;
  logic [DW-1:0]     dv_quo;

  scl_div_weights #(
    .IN_W(IN_W), .W_W(WW),
    .LIM_STD(LIM_STD), .LIM_FAST(LIM_FAST), .LIM_PLUS(LIM_PLUS)
  ) i_weights (
    .fscl(fscl_hz),
    .w_hi(w_hi),
    .w_lo(w_lo)
  );

  always_comb begin
    den_low = (DW'(fscl_hz) << 3) * (DW'(w_hi) + DW'(w_lo));
    num_low = DW'(fclk_hz) * DW'(w_lo) + den_low - 1'b1;
    unit_q  = DW'(fscl_q) << 3;
  end

  scl_div_divider #(.W(DW)) i_div (
    .clk(clk),
    .rst(rst),
    .go(go_q),
    .num(num_q),
    .den(den_q),
    .busy(dv_busy),
    .vld(dv_vld),
    .quo(dv_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      fclk_q  <= '0;
      fscl_q  <= '0;
      num_q   <= '0;
      den_q   <= '0;
      lt_q    <= '0;
      go_q    <= 1'b0;
      ready_q <= 1'b0;
      fault_q <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      go_q    <= 1'b0;
      ready_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            fclk_q <= fclk_hz;
            fscl_q <= fscl_hz;
            if (fscl_hz == '0) begin
              fault_q <= 1'b1;
              hi_q    <= '0;
              lo_q    <= '0;
              ready_q <= 1'b1;
            end else begin
              num_q <= num_low;
              den_q <= den_low;
              go_q  <= 1'b1;
              st_q  <= ST_LOW;
            end
          end
        end
        ST_LOW: begin
          if (dv_vld) begin
            lt_q  <= dv_quo;
            num_q <= DW'(fclk_q) + unit_q - 1'b1;
            den_q <= unit_q;
            go_q  <= 1'b1;
            st_q  <= ST_TOT;
          end
        end
        ST_TOT: begin
          if (dv_vld) begin
            hi_q    <= to_code(dv_quo - lt_q);
            lo_q    <= to_code(lt_q);
            fault_q <= 1'b0;
            ready_q <= 1'b1;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign ready   = ready_q;
  assign fault   = fault_q;
  assign hi_code = hi_q;
  assign lo_code = lo_q;

  // R6: the whole period is never shorter than its LOW share
  p_total_ge_low_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TOT && dv_vld) |-> (dv_quo >= lt_q));
  // R8: a fault result carries zero codes
  p_fault_zero_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> (hi_code == '0 && lo_code == '0));
  // R9: a start during a computation leaves the latched request alone
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(fclk_q) && $stable(fscl_q)));
  // R10: outputs move only together with the ready pulse
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ($stable(hi_code) && $stable(lo_code) && $stable(fault)) || ready);
  // R10: ready lasts one cycle
  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  // R1: the LOW weight always exceeds the HIGH weight
  p_weight_order_r1: assert property (@(posedge clk) disable iff (rst)
    w_lo > w_hi);
  // R5: the divider is never restarted mid-run
  p_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
    go_q |-> !dv_busy);
endmodule

// File: tb/test_scl_div_calc.sv
module test_scl_div_calc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] fclk_hz = '0;
  logic [31:0] fscl_hz = '0;
  logic        busy, ready, fault;
  logic [15:0] hi_code, lo_code;

  int checks = 0;
  int fails  = 0;
  int unexpected = 0;
  logic prev_ready = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  scl_div_calc i_scl_div_calc (
    .clk(clk), .rst(rst), .start(start),
    .fclk_hz(fclk_hz), .fscl_hz(fscl_hz),
    .busy(busy), .ready(ready), .fault(fault),
    .hi_code(hi_code), .lo_code(lo_code)
  );

  function automatic logic [15:0] sat16(input longint unsigned t);
    if (t == 0) return 16'd0;
    if (t - 1 > 64'hFFFF) return 16'hFFFF;
    return 16'(t - 1);
  endfunction

  // {fault, hi, lo} from the requirement formulas
  function automatic logic [32:0] model(input longint unsigned fc, input longint unsigned fs);
    longint unsigned h, l, d1, lt, tt;
    if (fs == 0) return {1'b1, 32'd0};
    if (fs <= 100000)       begin h = 40; l = 47; end
    else if (fs <= 400000)  begin h = 6;  l = 13; end
    else if (fs <= 1000000) begin h = 26; l = 50; end
    else                    begin h = 6;  l = 16; end
    d1 = fs * 8 * (h + l);
    lt = (fc * l + d1 - 1) / d1;
    tt = (fc + fs * 8 - 1) / (fs * 8);
    return {1'b0, sat16(tt - lt), sat16(lt)};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items when results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (ready && prev_ready)
        check(1'b0, "R10", "ready longer than one cycle", 1, 0);
      if (ready && !prev_ready) begin
        if (exp_q.size() == 0) begin
          unexpected++;
          check(1'b0, "R9", "ready without a pending request", 1, 0);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({fault, hi_code, lo_code} == e, t, "fault/hi/lo",
                {fault, hi_code, lo_code}, e);
        end
      end
      prev_ready = ready;
    end
  end

  task automatic request(input logic [31:0] fc, input logic [31:0] fs, input string tag);
    @(negedge clk);
    fclk_hz = fc;
    fscl_hz = fs;
    start   = 1'b1;
    exp_q.push_back(model(fc, fs));
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(!busy && !ready && !fault, "R11", "status after reset", {busy, ready, fault}, 0);
    check(hi_code == 0 && lo_code == 0, "R11", "codes after reset", {hi_code, lo_code}, 0);

    request(32'd12800000, 32'd400000, "R6");
    check(hi_code == 16'd0 && lo_code == 16'd2, "R6", "worked example", {hi_code, lo_code}, 32'h0000_0002);
    request(32'd50000000,  32'd100000,  "R1");
    request(32'd50000000,  32'd100001,  "R2");
    request(32'd24000000,  32'd400000,  "R2");
    request(32'd24000000,  32'd400001,  "R3");
    request(32'd100000000, 32'd1000000, "R3");
    request(32'd100000000, 32'd1000001, "R4");
    request(32'd200000000, 32'd3400000, "R4");
    request(32'd33000000,  32'd77777,   "R5");
    request(32'd8,         32'd1,       "R6");
    request(32'd0,         32'd400000,  "R5");
    request(32'hFFFFFFFF,  32'd1,       "R7");
    request(32'd100000000, 32'd100,     "R7");
    // R8 fault then recovery
    request(32'd50000000,  32'd0,       "R8");
    check(fault == 1'b1, "R8", "fault flag set", fault, 1);
    request(32'd50000000,  32'd400000,  "R8");
    check(fault == 1'b0, "R8", "fault flag cleared", fault, 0);

    // R9 start while busy
    @(negedge clk);
    fclk_hz = 32'd40000000;
    fscl_hz = 32'd100000;
    start   = 1'b1;
    exp_q.push_back(model(32'd40000000, 32'd100000));
    tag_q.push_back("R9");
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check(busy == 1'b1, "R9", "busy during computation", busy, 1);
    fclk_hz = 32'd1000;
    fscl_hz = 32'd3000000;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (200) @(negedge clk);
    check(unexpected == 0, "R9", "extra ready pulses", unexpected, 0);
    check({hi_code, lo_code} == model(32'd40000000, 32'd100000) >> 0 & 33'h0FFFFFFFF,
          "R9", "codes kept from first request", {hi_code, lo_code},
          model(32'd40000000, 32'd100000) & 33'h0FFFFFFFF);
    check(!busy, "R10", "idle after result", busy, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule